// File: doc/BRIEF.md
# System Interrupt Router with Level Mapping

This block is the chip-level interrupt router. It samples 32 level-sensitive hardware request lines into a pending word on every clock. A fixed, irregular table converts each request line into a processor interrupt level from 1 to 15. Several lines share a level, and lines with table entry 0 are dropped entirely. A disable mask gates the requests. Bit 31 of the mask is a master switch that silences all hardware levels. The resulting 16-bit level vector is sent to a single selectable CPU, and every other CPU receives zeros from the router. Lines that map to level 15 also drive a broadcast line that goes to all CPUs and ignores the mask.

Software reaches the block through a word-indexed register port with five locations: pending (read), mask (read), mask-clear (write), mask-set (write) and target CPU (read/write). The block also exports the unmasked level vector so the target CPU's local controller can mirror it. Per-CPU timer requests pass through the block unchanged.

Top module: `irq_router`

## Requirements
- R1: The pending word equals the source inputs of the previous clock, restricted to lines with a nonzero level; lines 23, 24, 25, 26 and 31 always read 0. Reading word offset 0 returns the pending word.
- R2: Each pending line maps to a level bit (bit L of a 16-bit vector means level L). The levels for lines 0..31 are 2,3,5,7,9,11,13,2,3,5,7,9,11,13,12,12,6,13,4,10,8,9,11,0,0,0,0,15,15,15,15,0. Bit 0 of any level vector is never set.
- R3: Writing word offset 3 ORs the written data, ANDed with 32'hF05DFF80, into the mask. Writing offset 2 clears the mask bits that are set in (data AND 32'hF05DFF80). Reading offset 1 returns the mask. Other bits of the mask never become 1.
- R4: A mask write does not change the pending word.
- R5: Writing word offset 4 stores data[3:0] as the target. Reading offset 4 returns the target zero-extended.
- R6: CPU c's level vector equals the mapping of (pending AND NOT mask) when the target equals c, mask bit 31 is clear, and at least one unmasked line is pending. Otherwise it is zero. A target of NCPU or above selects no CPU.
- R7: While mask bit 31 is set, every CPU's level vector is zero.
- R8: The level-15 broadcast output is high exactly when pending lines 27..30 contain a 1, regardless of the mask and the target.
- R9: The display output is the level mapping of the pending word without the mask.
- R10: The timer outputs equal the timer inputs in the same cycle.
- R11: After reset, the pending word, the mask and the target are all zero.
- R12: Reads of offsets 2, 3, 5, 6 and 7 return zero. Writes to offsets 0, 1, 5, 6 and 7 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| src_i | input | 32 | Hardware request levels |
| timer_i | input | NCPU | Per-CPU timer requests |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Word offset for read and write |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i |
| cpu_lvl_o | output | NCPU*16 | Level vectors, CPU c at bits [c*16 +: 16] |
| bcast15_o | output | 1 | Level-15 broadcast to all CPUs |
| disp_lvl_o | output | 16 | Unmasked level vector |
| timer_o | output | NCPU | Timer pass-through |

## Verification
The first sweep drives each of the 32 request lines on its own while the target rotates across the CPUs. This confirms every table entry, the dropped lines and the broadcast lines, and shows that only the selected CPU receives levels. A second phase applies long pseudo-random request words, mixed with random mask-set, mask-clear and target writes, including target values at or above the CPU count. Here shared levels collapse onto one bit, the master bit silences the CPUs while the broadcast stays live, and the masked path can be told apart from the display path. Directed writes to the unused and read-only offsets show that they alter nothing.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  localparam int NSRC  = 32;
  localparam int NLVL  = 16;
  localparam int TGT_W = 4;
  localparam int MDIS  = 31;
  localparam logic [NSRC-1:0] MASK_IMPL = 32'hF05DFF80;

  typedef enum logic [2:0] {
    OFF_PEND = 3'd0,
    OFF_MASK = 3'd1,
    OFF_CLR  = 3'd2,
    OFF_SET  = 3'd3,
    OFF_TGT  = 3'd4
  } reg_off_e;

  function automatic logic [3:0] src_lvl(input int unsigned b);
    case (b)
      0, 7:            return 4'd2;
      1, 8:            return 4'd3;
      2, 9:            return 4'd5;
      3, 10:           return 4'd7;
      4, 11, 21:       return 4'd9;
      5, 12, 22:       return 4'd11;
      6, 13, 17:       return 4'd13;
      14, 15:          return 4'd12;
      16:              return 4'd6;
      18:              return 4'd4;
      19:              return 4'd10;
      20:              return 4'd8;
      27, 28, 29, 30:  return 4'd15;
      default:         return 4'd0;
    endcase
  endfunction

  function automatic logic [NSRC-1:0] live_mask();
    logic [NSRC-1:0] m;
    for (int b = 0; b < NSRC; b++) m[b] = (src_lvl(b) != 4'd0);
    return m;
  endfunction

  function automatic logic [NSRC-1:0] top_mask();
    logic [NSRC-1:0] m;
    for (int b = 0; b < NSRC; b++) m[b] = (src_lvl(b) == 4'd15);
    return m;
  endfunction
endpackage

// File: rtl/irq_regs.sv
module irq_regs
  import irq_router_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NSRC-1:0]  src_i,
  input  logic             wr_en_i,
  input  logic [2:0]       addr_i,
  input  logic [NSRC-1:0]  wdata_i,
  output logic [NSRC-1:0]  pend_o,
  output logic [NSRC-1:0]  mask_o,
  output logic [TGT_W-1:0] tgt_o,
  output logic [NSRC-1:0]  rdata_o
);
  localparam logic [NSRC-1:0] LIVE = live_mask();

  logic [NSRC-1:0]  pend_q, mask_q, wmask;
  logic [TGT_W-1:0] tgt_q;

  assign wmask = wdata_i & MASK_IMPL;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      mask_q <= '0;
      tgt_q  <= '0;
    end else begin
      pend_q <= src_i & LIVE;
      if (wr_en_i) begin
        unique case (addr_i)
          OFF_CLR: mask_q <= mask_q & ~wmask;
          OFF_SET: mask_q <= mask_q | wmask;
          OFF_TGT: tgt_q  <= wdata_i[TGT_W-1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    unique case (addr_i)
      OFF_PEND: rdata_o = pend_q & ~(NSRC'(1) << MDIS);
      OFF_MASK: rdata_o = mask_q & MASK_IMPL;
      OFF_TGT:  rdata_o = NSRC'(tgt_q);
      default:  rdata_o = '0;
    endcase
  end

  assign pend_o = pend_q;
  assign mask_o = mask_q;
  assign tgt_o  = tgt_q;
endmodule

// File: rtl/irq_lvl_map.sv
module irq_lvl_map
  import irq_router_pkg::*;
(
  input  logic [NSRC-1:0] word_i,
  output logic [NLVL-1:0] lvl_o
);
  always_comb begin
    lvl_o = '0;
    for (int b = 0; b < NSRC; b++)
      if (word_i[b]) lvl_o[src_lvl(b)] = 1'b1;
    lvl_o[0] = 1'b0;  // level 0 means "no interrupt"
  end
endmodule

// File: rtl/irq_steer.sv
module irq_steer
  import irq_router_pkg::*;
#(
  parameter int NCPU = 4
) (
  input  logic [NLVL-1:0]      lvl_i,
  input  logic                 active_i,
  input  logic [TGT_W-1:0]     tgt_i,
  output logic [NCPU*NLVL-1:0] cpu_lvl_o
);
  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    assign cpu_lvl_o[c*NLVL +: NLVL] =
      (active_i && tgt_i == TGT_W'(c)) ? lvl_i : '0;
  end
endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_router_pkg::*;
#(
  parameter int NCPU = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [31:0]          src_i,
  input  logic [NCPU-1:0]      timer_i,
  input  logic                 wr_en_i,
  input  logic [2:0]           addr_i,
  input  logic [31:0]          wdata_i,
  output logic [31:0]          rdata_o,
  output logic [NCPU*16-1:0]   cpu_lvl_o,
  output logic                 bcast15_o,
  output logic [15:0]          disp_lvl_o,
  output logic [NCPU-1:0]      timer_o
);
  localparam logic [NSRC-1:0] TOP = top_mask();

  logic [NSRC-1:0]  pend_q, mask_q, live_req;
  logic [TGT_W-1:0] tgt_q;
  logic [NLVL-1:0]  req_lvl;
  logic             active;

  irq_regs u_regs (
    .clk_i, .rst_ni, .src_i, .wr_en_i, .addr_i, .wdata_i,
    .pend_o(pend_q), .mask_o(mask_q), .tgt_o(tgt_q), .rdata_o
  );

  assign live_req = pend_q & ~mask_q;
  assign active   = !mask_q[MDIS] && (|live_req);

  irq_lvl_map u_map_req  (.word_i(live_req), .lvl_o(req_lvl));
  irq_lvl_map u_map_disp (.word_i(pend_q),   .lvl_o(disp_lvl_o));

  irq_steer #(.NCPU(NCPU)) u_steer (
    .lvl_i(req_lvl), .active_i(active), .tgt_i(tgt_q), .cpu_lvl_o
  );

  assign bcast15_o = |(pend_q & TOP);
  assign timer_o   = timer_i;
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk
  import irq_router_pkg::*;
#(
  parameter int NCPU = 4
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [31:0]          src_i,
  input logic                 wr_en_i,
  input logic [2:0]           addr_i,
  input logic [31:0]          wdata_i,
  input logic [NCPU*16-1:0]   cpu_lvl_o,
  input logic                 bcast15_o,
  input logic [31:0]          mask_q,
  input logic [3:0]           tgt_q
);
  logic [NCPU-1:0] any_cpu;
  logic [NCPU-1:0] lvl0_bits;
  logic            armed;

  always_comb
    for (int c = 0; c < NCPU; c++) begin
      any_cpu[c]   = |cpu_lvl_o[c*16 +: 16];
      lvl0_bits[c] = cpu_lvl_o[c*16];
    end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) armed <= 1'b0;
    else         armed <= 1'b1;

  p_single_target_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(any_cpu));

  p_master_off_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_q[31] |-> (cpu_lvl_o == '0));

  p_no_level0_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lvl0_bits == '0);

  p_tgt_write_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == 3'd4) |=> (tgt_q == $past(wdata_i[3:0])));

  p_mask_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == 3'd3) |=>
      ((mask_q & $past(wdata_i) & MASK_IMPL) == ($past(wdata_i) & MASK_IMPL)));

  p_mask_impl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_q & ~MASK_IMPL) == '0);

  p_bcast_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed |-> (bcast15_o == $past(|src_i[30:27])));
endmodule

bind irq_router irq_router_chk #(.NCPU(NCPU)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .src_i(src_i), .wr_en_i(wr_en_i),
  .addr_i(addr_i), .wdata_i(wdata_i), .cpu_lvl_o(cpu_lvl_o),
  .bcast15_o(bcast15_o), .mask_q(mask_q), .tgt_q(tgt_q)
);

// File: tb/irq_router_test.sv
module irq_router_test;
  localparam int NCPU = 4;

  logic                clk_i = 1'b0;
  logic                rst_ni = 1'b0;
  logic [31:0]         src_i = '0;
  logic [NCPU-1:0]     timer_i = '0;
  logic                wr_en_i = 1'b0;
  logic [2:0]          addr_i = '0;
  logic [31:0]         wdata_i = '0;
  logic [31:0]         rdata_o;
  logic [NCPU*16-1:0]  cpu_lvl_o;
  logic                bcast15_o;
  logic [15:0]         disp_lvl_o;
  logic [NCPU-1:0]     timer_o;

  irq_router #(.NCPU(NCPU)) uut (.*);

  always #5 clk_i = ~clk_i;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // requirement table, level per line
  int lvl_tab [32] = '{2,3,5,7,9,11,13,2, 3,5,7,9,11,13,12,12,
                       6,13,4,10,8,9,11,0, 0,0,0,15,15,15,15,0};
  localparam logic [31:0] IMPL = 32'hF05DFF80;

  logic [31:0] m_pend = '0, m_mask = '0;
  logic [3:0]  m_tgt = '0;

  function automatic logic [31:0] live();
    logic [31:0] m;
    for (int b = 0; b < 32; b++) m[b] = (lvl_tab[b] != 0);
    return m;
  endfunction

  function automatic logic [15:0] map(input logic [31:0] w);
    logic [15:0] v = '0;
    for (int b = 0; b < 32; b++)
      if (w[b] && lvl_tab[b] != 0) v[lvl_tab[b]] = 1'b1;
    return v;
  endfunction

  function automatic logic [NCPU*16-1:0] exp_cpu();
    logic [NCPU*16-1:0] e = '0;
    logic [31:0] lr = m_pend & ~m_mask;
    for (int c = 0; c < NCPU; c++)
      if (m_tgt == 4'(c) && !m_mask[31] && lr != 0) e[c*16 +: 16] = map(lr);
    return e;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    if (wr_en_i) begin
      case (addr_i)
        3'd2: m_mask = m_mask & ~(wdata_i & IMPL);
        3'd3: m_mask = m_mask | (wdata_i & IMPL);
        3'd4: m_tgt  = wdata_i[3:0];
        default: ;
      endcase
    end
    m_pend = src_i & live();
    #1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    tick();
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input string req, input logic [2:0] a, input logic [31:0] exp);
    addr_i = a; #1;
    chk(req, 64'(rdata_o), 64'(exp));
  endtask

  task automatic chk_outs(input string tag);
    chk({tag, " R6 cpu levels"}, 64'(cpu_lvl_o), 64'(exp_cpu()));
    chk({tag, " R9 display"}, 64'(disp_lvl_o), 64'(map(m_pend)));
    chk({tag, " R8 bcast"}, 64'(bcast15_o), 64'(|m_pend[30:27]));
  endtask

  initial begin
    #200000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] lfsr = 32'hACE1_1234;
    #23 rst_ni = 1'b1;
    #2;
    // R11 reset values
    rd("R11 pending", 3'd0, 32'h0);
    rd("R11 mask", 3'd1, 32'h0);
    rd("R11 target", 3'd4, 32'h0);
    chk("R11 cpu levels", 64'(cpu_lvl_o), 64'h0);

    // R10 timer pass-through
    timer_i = 4'b1010; #1;
    chk("R10 timer", 64'(timer_o), 64'(4'b1010));
    timer_i = 4'b0101; #1;
    chk("R10 timer", 64'(timer_o), 64'(4'b0101));

    // R1/R2: single-line sweep, target rotates
    for (int b = 0; b < 32; b++) begin
      wr(3'd4, 32'(b % NCPU));
      src_i = 32'h1 << b;
      tick();
      rd("R1 pending", 3'd0, m_pend);
      chk("R2 single line map", 64'(cpu_lvl_o), 64'(exp_cpu()));
      chk_outs("sweep");
    end

    // R3/R7/R4: mask everything, master bit set
    src_i = 32'h0800_0005; tick();
    wr(3'd3, 32'hFFFF_FFFF);
    rd("R3 mask set", 3'd1, 32'hF05DFF80);
    rd("R4 pending kept", 3'd0, 32'h0800_0005);
    chk("R7 master off", 64'(cpu_lvl_o), 64'h0);
    chk("R8 bcast while masked", 64'(bcast15_o), 64'h1);
    wr(3'd2, 32'h8000_0000);
    rd("R3 mask clear", 3'd1, 32'h705DFF80);
    chk("R3 unmaskable line 0 reaches cpu", 64'(cpu_lvl_o), 64'(exp_cpu()));

    // R12: ignored writes, zero reads
    wr(3'd0, 32'hFFFF_FFFF);
    wr(3'd1, 32'h0000_0000);
    wr(3'd5, 32'hFFFF_FFFF);
    wr(3'd7, 32'h0000_000F);
    rd("R12 mask unchanged", 3'd1, 32'h705DFF80);
    rd("R12 target unchanged", 3'd4, 32'(m_tgt));
    rd("R12 pending unchanged", 3'd0, 32'h0800_0005);
    rd("R12 read off2", 3'd2, 32'h0);
    rd("R12 read off3", 3'd3, 32'h0);
    rd("R12 read off5", 3'd5, 32'h0);
    rd("R12 read off6", 3'd6, 32'h0);
    rd("R12 read off7", 3'd7, 32'h0);

    // R5 target width
    wr(3'd4, 32'hFFFF_FFF2);
    rd("R5 target low bits", 3'd4, 32'h2);

    // random patterns with register traffic
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      src_i = lfsr ^ {lfsr[15:0], lfsr[31:16]};
      case (lfsr[3:1])
        3'd0, 3'd1: wr(3'd2, {lfsr[7:0], lfsr[31:8]});
        3'd2:       wr(3'd3, {lfsr[15:0], lfsr[31:16]} & {8'h7F, 24'hFFFFFF});
        3'd3:       wr(3'd3, 32'h8000_0000 & {32{lfsr[5]}});
        3'd4, 3'd5: wr(3'd4, 32'(lfsr[11:8]));
        default:    tick();
      endcase
      if (i % 4 == 0) tick();
      chk_outs("random");
      rd("R3 mask readback", 3'd1, m_mask);
      rd("R1 pending readback", 3'd0, m_pend);
      rd("R5 target readback", 3'd4, 32'(m_tgt));
    end

    // R6: target out of range selects nobody
    wr(3'd2, 32'hFFFF_FFFF);
    src_i = 32'h0000_00FF; tick();
    wr(3'd4, 32'd9);
    chk("R6 out-of-range target", 64'(cpu_lvl_o), 64'h0);
    chk("R9 display still live", 64'(disp_lvl_o), 64'(map(m_pend)));

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule